// File: doc/BRIEF.md
# Multi-step Galois LFSR bank

This block is a source of pseudo-random bits for a Gaussian noise datapath. The bits address the lookup tables of that datapath and pick the sign of each sample. It holds eight shift registers of different lengths. Each register uses the Galois ("one to many") arrangement: the bit that drops off the top of the word is XORed back into the tapped positions.

Each register runs several shift steps in every clock cycle through unrolled feedback logic. As a result, every register hands a packet of fresh bits to the consumer on each enabled cycle. The consumer sees one flat output word that joins the packets of all eight registers.

A synchronous reset loads each register with its own nonzero seed. An enable input lets the whole bank pause with its state kept.

Top module: `lfsr_bank`

## Requirements
- R1: One step of a register shifts its word left by one position and puts 0 in bit 0. When the bit shifted out of the top was 1, the register's feedback mask is XORed into the shifted word.
- R2: On a rising clock edge with `en` high and `rst` low, every register advances by exactly STEPS single steps (default 4).
- R3: The length-5 register uses mask 00101 (x^5+x^2+1). Seeded with 00001, the register visits on successive enabled cycles exactly every fourth state of the one-step sequence that starts from 00001.
- R4: On a rising edge with `rst` high, each register loads its own nonzero seed. With the default seeds the output packets afterwards are, lane 0 to lane 7: 1, 7, 1, 5, 4, A, 1, B (hex).
- R5: On a rising edge with `rst` low and `en` low, no register changes, so `rndBits` stays the same.
- R6: The eight lanes, in lane order 0..7, have lengths 22, 21, 20, 17, 13, 7, 5 and 15. Their masks are 0x3, 0x5, 0x9, 0x9, 0x1B, 0x3, 0x5 and 0x3.
- R7: `rndBits[STEPS*i +: STEPS]` carries the low STEPS bits of lane i's state.
- R8: No register ever holds the all-zero word. The length-5 lane comes back to its seed after 31 enabled cycles.
- R9: When `rst` and `en` are both high, reset wins and the seeds are loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, loads the seeds |
| en | input | 1 | Advance enable; low holds all state |
| rndBits | output | 8*STEPS | Joined packets, lane 0 in the low bits |

## Verification
The bench builds the block with its default parameters: STEPS of 4 and the default seeds, including seed 00001 on the length-5 lane. These values make the length-5 lane's full 31-state period short enough to go through completely, so the every-fourth-state property and the return to the seed can both be observed. The enable patterns are continuous, irregular and held low, and one reset is applied while enable is high. Together they cover advance, hold and reset priority on all eight lanes against a step-by-step model.

// File: rtl/lfsr_bank_pkg.sv
package lfsr_bank_pkg;

  localparam int NUM_LANES = 8;
  localparam int MAX_LEN   = 22;

  typedef int unsigned laneLen_t [NUM_LANES];
  typedef logic [MAX_LEN-1:0] laneWord_t [NUM_LANES];

  // Register lengths per lane; lane 0 sits in the low output bits.
  localparam laneLen_t LANE_LEN = '{22, 21, 20, 17, 13, 7, 5, 15};

  // Feedback masks: the low taps of each polynomial, top term implied.
  localparam laneWord_t LANE_MASK = '{
    22'h00003, 22'h00005, 22'h00009, 22'h00009,
    22'h0001B, 22'h00003, 22'h00005, 22'h00003
  };

  // Nonzero seeds loaded on reset.
  localparam laneWord_t LANE_SEED = '{
    22'h2A5F1, 22'h1B3C7, 22'h0F0D1, 22'h1ACE5,
    22'h01234, 22'h0005A, 22'h00001, 22'h04C3B
  };

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
    logic advance;
  } lfsrStrobe_t;

endpackage

// File: rtl/lfsr_bank_ctrl.sv
module lfsr_bank_ctrl
  import lfsr_bank_pkg::*;
(
  input  logic        rst,
  input  logic        en,
  output lfsrStrobe_t strobe
);

  // Reset has priority over advance.
  always_comb begin
    strobe.load    = rst;
    strobe.advance = en & ~rst;
  end

endmodule

// File: rtl/lfsr_bank_lane.sv
module lfsr_bank_lane
  import lfsr_bank_pkg::*;
#(
  parameter int unsigned LEN   = 5,
  parameter int unsigned STEPS = 4,
  parameter logic [LEN-1:0] MASK = '0,
  parameter logic [LEN-1:0] SEED = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  lfsrStrobe_t      strobe,
  output logic [STEPS-1:0] packet
);

  logic [LEN-1:0] state;
  logic [LEN-1:0] jumpState;

  // STEPS single Galois steps chained in one cycle.
  always_comb begin
    jumpState = state;
    for (int k = 0; k < STEPS; k++) begin
      if (jumpState[LEN-1]) jumpState = {jumpState[LEN-2:0], 1'b0} ^ MASK;
      else                  jumpState = {jumpState[LEN-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load)         state <= SEED;
    else if (strobe.advance) state <= jumpState;
  end

  assign packet = state[STEPS-1:0];

  // R8
  nonzero_state_chk: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  // R5
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.advance && !strobe.load) |=> $stable(state));

  // R2
  advance_moves_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.advance |=> state != $past(state));

  // R4
  seed_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state == SEED);

endmodule

// File: rtl/lfsr_bank_dp.sv
module lfsr_bank_dp
  import lfsr_bank_pkg::*;
#(
  parameter int unsigned STEPS = 4,
  localparam int unsigned OUT_W = NUM_LANES * STEPS
) (
  input  logic             clk,
  input  logic             rst,
  input  lfsrStrobe_t      strobe,
  output logic [OUT_W-1:0] rndBits
);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned L = LANE_LEN[g];
    lfsr_bank_lane #(
      .LEN  (L),
      .STEPS(STEPS),
      .MASK (LANE_MASK[g][L-1:0]),
      .SEED (LANE_SEED[g][L-1:0])
    ) u_lane (
      .clk   (clk),
      .rst   (rst),
      .strobe(strobe),
      .packet(rndBits[STEPS*g +: STEPS])
    );
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.advance && !strobe.load) |=> $stable(rndBits));

endmodule

// File: rtl/lfsr_bank.sv
module lfsr_bank
  import lfsr_bank_pkg::*;
#(
  parameter int unsigned STEPS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  output logic [NUM_LANES*STEPS-1:0]   rndBits
);

  lfsrStrobe_t strobe;

  lfsr_bank_ctrl u_ctrl (
    .rst   (rst),
    .en    (en),
    .strobe(strobe)
  );

  lfsr_bank_dp #(.STEPS(STEPS)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .rndBits(rndBits)
  );

endmodule

// File: tb/lfsr_bank_tb.sv
module lfsr_bank_tb;

  localparam int STEPS = 4;
  localparam int LANES = 8;

  logic clk = 0;
  logic rst = 1;
  logic en  = 0;
  logic [LANES*STEPS-1:0] rndBits;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  int     lens  [LANES] = '{22, 21, 20, 17, 13, 7, 5, 15};
  longint masks [LANES] = '{64'h3, 64'h5, 64'h9, 64'h9, 64'h1B, 64'h3, 64'h5, 64'h3};
  longint seeds [LANES] = '{64'h2A5F1, 64'h1B3C7, 64'h0F0D1, 64'h1ACE5,
                            64'h01234, 64'h0005A, 64'h00001, 64'h04C3B};
  longint model [LANES];
  longint oneStep [$];

  always #5 clk = ~clk;

  lfsr_bank u_dut (.clk(clk), .rst(rst), .en(en), .rndBits(rndBits));

  // R1: behavioural single step
  function automatic longint stepOnce(longint s, int len, longint m);
    longint top;
    top = (s >> (len - 1)) & 1;
    s = (s << 1) & ((64'd1 << len) - 1);
    if (top == 1) s = s ^ m;
    return s;
  endfunction

  function automatic void modelEdge(bit r, bit e);
    for (int i = 0; i < LANES; i++) begin
      if (r) model[i] = seeds[i];
      else if (e) for (int k = 0; k < STEPS; k++) model[i] = stepOnce(model[i], lens[i], masks[i]);
    end
  endfunction

  task automatic compareAll(string tag);
    for (int i = 0; i < LANES; i++) begin
      longint expv;
      logic [STEPS-1:0] act;
      expv = model[i] & ((64'd1 << STEPS) - 1);
      act  = rndBits[STEPS*i +: STEPS];
      vectors++;
      if (act !== expv[STEPS-1:0]) begin
        errors++;
        $display("FAIL %s lane %0d: actual %h expected %h", tag, i, act, expv[STEPS-1:0]);
      end
    end
  endtask

  task automatic checkOne(string tag, logic [STEPS-1:0] act, logic [STEPS-1:0] expv);
    vectors++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // drive at negedge, model reflects the coming posedge
  task automatic cycle(bit r, bit e, string tag);
    @(negedge clk);
    compareAll(tag);
    rst = r;
    en  = e;
    modelEdge(r, e);
  endtask

  initial begin
    // one-step reference sequence for the length-5 lane from 00001 (R3)
    begin
      longint s = 1;
      for (int k = 0; k < 200; k++) begin
        oneStep.push_back(s);
        s = stepOnce(s, 5, 64'h5);
      end
    end
    modelEdge(1, 0);
    rst = 1; en = 0;
    repeat (3) @(negedge clk);
    // R4: seeds visible after reset
    compareAll("R4 reset seeds");
    checkOne("R4 lane0 packet", rndBits[3:0], 4'h1);
    checkOne("R4 lane7 packet", rndBits[31:28], 4'hB);
    rst = 0; en = 1;
    modelEdge(0, 1);
    // R3 and R8 on the length-5 lane, continuous enable
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      compareAll("R1 R2 R6 R7 continuous");
      checkOne("R3 every fourth state", rndBits[27:24], oneStep[4*c][3:0]);
      if (c == 31) checkOne("R8 length-5 period", rndBits[27:24], 4'h1);
      modelEdge(0, 1);
    end
    for (int c = 0; c < 300; c++) cycle(0, 1, "R2 continuous run");
    // irregular enable
    for (int c = 0; c < 400; c++) cycle(0, (c % 3 != 0) && (c % 7 != 2), "R5 irregular enable");
    // long hold
    for (int c = 0; c < 30; c++) cycle(0, 0, "R5 held");
    // reset with enable high: reset wins
    cycle(1, 1, "R2 before reset");
    cycle(0, 1, "R9 reset priority");
    for (int c = 0; c < 2000; c++) cycle(0, 1, "R1 R6 R7 long run");
    @(negedge clk);
    compareAll("R2 final");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule